// File: doc/BRIEF.md
# PIO Timing Count Calculator

This block turns the timing of one drive's programmed-I/O transfer, given in nanoseconds, into the clock counts that a transfer timing generator is loaded with. The caller supplies the address setup time, the strobe active time, the full cycle time and the bus clock period. The block returns a setup count, an active count and a recovery count, each clamped to the range the timing generator accepts and adjusted for the silicon revision.

On the secondary channel, the two drives share one set of timing counts. When the partner drive is present, the caller sets the merge input and supplies the partner's final counts. The block then returns the slower value of each count, taken one count at a time.

The calculation runs over several cycles. A one-cycle start pulse captures every input. One shared subtract-and-count divider then works out the four quotients in turn. A one-cycle done pulse marks the moment the three count outputs take their new values.

Top module: `pio_cnt_calc`

## Requirements
- R1: Each raw count is the time divided by the clock period, rounded up. A time of zero or less gives a count of 0. For example, 60 ns at 30 ns gives 2, and 61 ns gives 3. The setup count is output unclamped, saturating at 255.
- R2: The raw recovery count is the larger of two values. The first is the rounded-up recovery time, where recovery time is the cycle time minus the setup time minus the active time. The second is the cycle count minus the setup count minus the active count. A negative value counts as 0.
- R3: The active count is raised to at least 2 before R2 is evaluated. The recovery count is raised to at least 2 before R4.
- R4: If the recovery count exceeds 17, the excess is added to the active count and recovery becomes 17. The active count is then capped at 16.
- R5: When the revision input is greater than 1, one is subtracted from the recovery count. Recovery is then capped at 16.
- R6: When the merge input is 1, each output count is the maximum of the block's own count and the matching partner count. When the merge input is 0, the partner counts have no effect.
- R7: Start is accepted only while busy is low, and it captures every input. Busy is high from the next cycle until done. Done is a single-cycle pulse, and busy is low in that cycle. A start while busy is ignored.
- R8: After reset, busy and done are low and all count outputs are 0. The outputs change only in the cycle in which done is high.
- R9: A clock period input of 0 is treated as 1 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | start pulse; captures all inputs |
| setup_ns | input | TW | address setup time, ns |
| active_ns | input | TW | strobe active time, ns |
| cycle_ns | input | TW | full cycle time, ns |
| period_ns | input | PW | bus clock period, ns |
| rev | input | 2 | silicon revision |
| merge_en | input | 1 | partner present; merge counts |
| mate_setup | input | CW | partner setup count |
| mate_active | input | 5 | partner active count |
| mate_recov | input | 5 | partner recovery count |
| busy | output | 1 | calculation in progress |
| done | output | 1 | one-cycle result strobe |
| setup_cnt | output | CW | setup count |
| active_cnt | output | 5 | active count |
| recov_cnt | output | 5 | recovery count |

## Verification
The assertions check, on every cycle, the handshake and the result ranges:
- done lasts one cycle and ends a busy period;
- the count outputs stay stable outside done;
- every delivered active count lies in 2 to 16;
- every delivered recovery count lies in 1 to 16.

The exact arithmetic can only be shown by the bench's scenarios, which compare the outputs against hand-worked values. These scenarios cover rounding at an exact multiple of the period, moving excess recovery into the active phase, the active cap, negative recovery time, the revision adjustment, and the per-count merge.

// File: rtl/pio_cnt_calc.sv
module pio_cnt_calc #(
  parameter int TW = 16,
  parameter int PW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] setup_ns,
  input  logic [TW-1:0] active_ns,
  input  logic [TW-1:0] cycle_ns,
  input  logic [PW-1:0] period_ns,
  input  logic [1:0]    rev,
  input  logic          merge_en,
  input  logic [CW-1:0] mate_setup,
  input  logic [4:0]    mate_active,
  input  logic [4:0]    mate_recov,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] setup_cnt,
  output logic [4:0]    active_cnt,
  output logic [4:0]    recov_cnt
);
  localparam int SW = TW + 3;
  localparam int CMAX = (1 << CW) - 1;

  logic [TW-1:0] l_set, l_act, l_cyc;
  logic [PW-1:0] l_per;
  logic [1:0]    l_rev;
  logic          l_mrg, fin;
  logic [CW-1:0] l_mset;
  logic [4:0]    l_mact, l_mrec;
  logic signed [SW-1:0] rem;
  logic [TW-1:0] q, q_cyc, q_set, q_act, q_rt;
  logic [1:0]    idx;

  logic signed [SW-1:0] rt_ns, nxt_op;
  assign rt_ns = $signed({3'b0, l_cyc}) - $signed({3'b0, l_set}) - $signed({3'b0, l_act});

  always_comb begin
    case (idx)
      2'd0:    nxt_op = $signed({3'b0, l_set});
      2'd1:    nxt_op = $signed({3'b0, l_act});
      default: nxt_op = rt_ns;
    endcase
  end

  logic signed [SW-1:0] act0, r2, ra, rb, actc, rc, rd;
  logic [CW-1:0] set_f, set_m;
  logic [4:0]    act_f, rec_f;

  always_comb begin
    act0 = (q_act < 2) ? SW'(2) : $signed({3'b0, q_act});
    r2   = $signed({3'b0, q_cyc}) - $signed({3'b0, q_set}) - act0;
    if (r2 < 0) r2 = '0;
    ra   = ($signed({3'b0, q_rt}) > r2) ? $signed({3'b0, q_rt}) : r2;
    rb   = (ra < 2) ? SW'(2) : ra;
    actc = act0;
    rc   = rb;
    if (rb > 17) begin
      actc = act0 + rb - 17;
      rc   = 17;
    end
    if (actc > 16) actc = 16;
    rd = (l_rev > 2'd1) ? rc - 1 : rc;
    if (rd > 16) rd = 16;
    set_f = (q_set > TW'(CMAX)) ? CW'(CMAX) : q_set[CW-1:0];
    act_f = actc[4:0];
    rec_f = rd[4:0];
  end

  assign set_m = (l_mrg && l_mset > set_f) ? l_mset : set_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; fin <= 1'b0;
      l_set <= '0; l_act <= '0; l_cyc <= '0; l_per <= '0; l_rev <= '0;
      l_mrg <= 1'b0; l_mset <= '0; l_mact <= '0; l_mrec <= '0;
      rem <= '0; q <= '0; idx <= '0;
      q_cyc <= '0; q_set <= '0; q_act <= '0; q_rt <= '0;
      setup_cnt <= '0; active_cnt <= '0; recov_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          l_set <= setup_ns; l_act <= active_ns; l_cyc <= cycle_ns;
          l_per <= (period_ns == '0) ? PW'(1) : period_ns;
          l_rev <= rev; l_mrg <= merge_en;
          l_mset <= mate_setup; l_mact <= mate_active; l_mrec <= mate_recov;
          rem <= $signed({3'b0, cycle_ns});
          q <= '0; idx <= '0;
        end
      end else if (fin) begin
        fin <= 1'b0; busy <= 1'b0; done <= 1'b1;
        setup_cnt  <= set_m;
        active_cnt <= (l_mrg && l_mact > act_f) ? l_mact : act_f;
        recov_cnt  <= (l_mrg && l_mrec > rec_f) ? l_mrec : rec_f;
      end else if (rem > 0) begin
        rem <= rem - $signed({{(SW-PW){1'b0}}, l_per});
        q <= q + 1'b1;
      end else begin
        case (idx)
          2'd0:    q_cyc <= q;
          2'd1:    q_set <= q;
          2'd2:    q_act <= q;
          default: q_rt  <= q;
        endcase
        if (idx == 2'd3) fin <= 1'b1;
        else begin
          idx <= idx + 1'b1;
          rem <= nxt_op;
          q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/pio_cnt_calc_chk.sv
module pio_cnt_calc_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] setup_cnt,
  input logic [4:0]    active_cnt,
  input logic [4:0]    recov_cnt
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(setup_cnt) && $stable(active_cnt) && $stable(recov_cnt)));
  assert_active_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (active_cnt >= 5'd2 && active_cnt <= 5'd16));
  assert_recov_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (recov_cnt >= 5'd1 && recov_cnt <= 5'd16));
endmodule

bind pio_cnt_calc pio_cnt_calc_chk #(.CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .setup_cnt(setup_cnt), .active_cnt(active_cnt), .recov_cnt(recov_cnt)
);

// File: tb/test_pio_cnt_calc.sv
module test_pio_cnt_calc;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] setup_ns = '0, active_ns = '0, cycle_ns = '0;
  logic [7:0]  period_ns = '0;
  logic [1:0]  rev = '0;
  logic        merge_en = 1'b0;
  logic [7:0]  mate_setup = '0;
  logic [4:0]  mate_active = '0, mate_recov = '0;
  logic        busy, done;
  logic [7:0]  setup_cnt;
  logic [4:0]  active_cnt, recov_cnt;
  int total = 0, bad = 0;

  pio_cnt_calc i_pio_cnt_calc (.*);

  always #10 clk = ~clk;

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic run(int s, int a, int c, int p, int r, bit m,
                     int ms, int ma, int mr, int es, int ea, int er, string tag);
    int n;
    @(negedge clk);
    setup_ns = 16'(s); active_ns = 16'(a); cycle_ns = 16'(c); period_ns = 8'(p);
    rev = 2'(r); merge_en = m; mate_setup = 8'(ms); mate_active = 5'(ma); mate_recov = 5'(mr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk({tag, " setup"}, setup_cnt, es);
    chk({tag, " active"}, active_cnt, ea);
    chk({tag, " recov"}, recov_cnt, er);
    @(negedge clk);
    chk({tag, " R7 done pulse"}, done, 0);
  endtask

  task automatic t_reset;
    chk("R8 busy", busy, 0);
    chk("R8 done", done, 0);
    chk("R8 outputs", {setup_cnt, active_cnt, recov_cnt}, 0);
  endtask

  task automatic t_basic;
    run(70, 165, 600, 30, 1, 0, 0, 0, 0, 3, 6, 13, "R1 R2 basic");
    run(60, 150, 600, 30, 1, 0, 0, 0, 0, 2, 5, 13, "R1 exact");
    run(61, 150, 600, 30, 1, 0, 0, 0, 0, 3, 5, 13, "R1 round up");
  endtask

  task automatic t_rev;
    run(70, 165, 600, 30, 2, 0, 0, 0, 0, 3, 6, 12, "R5 rev2");
  endtask

  task automatic t_long_recovery;
    run(30, 30, 900, 30, 2, 0, 0, 0, 0, 1, 13, 16, "R4 excess");
    run(30, 300, 1200, 30, 1, 0, 0, 0, 0, 1, 16, 16, "R4 cap R5");
  endtask

  task automatic t_short_cycle;
    run(25, 70, 90, 30, 1, 0, 0, 0, 0, 1, 3, 2, "R3 R2 negative");
    run(25, 70, 90, 30, 3, 0, 0, 0, 0, 1, 3, 1, "R3 R5 rev3");
  endtask

  task automatic t_merge;
    run(70, 165, 600, 30, 1, 1, 5, 4, 14, 5, 6, 14, "R6 mixed");
    run(70, 165, 600, 30, 1, 1, 0, 0, 0, 3, 6, 13, "R6 zero mate");
    run(70, 165, 600, 30, 1, 0, 9, 16, 16, 3, 6, 13, "R6 merge off");
  endtask

  task automatic t_period_zero;
    run(3, 4, 10, 0, 1, 0, 0, 0, 0, 3, 4, 3, "R9 period0");
  endtask

  task automatic t_busy_ignore;
    int n;
    @(negedge clk);
    setup_ns = 70; active_ns = 165; cycle_ns = 600; period_ns = 30; rev = 1; merge_en = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 busy", busy, 1);
    repeat (3) @(negedge clk);
    setup_ns = 5; active_ns = 5; cycle_ns = 5; period_ns = 1; rev = 3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk("R7 ignore setup", setup_cnt, 3);
    chk("R7 ignore active", active_cnt, 6);
    chk("R7 ignore recov", recov_cnt, 13);
    chk("R7 busy low at done", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_basic;
    t_rev;
    t_long_recovery;
    t_short_cycle;
    t_merge;
    t_period_zero;
    t_busy_ignore;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule